// File: doc/BRIEF.md
# Locked-Load Reservation Tracker

This block sits beside a shared memory and decides, for every request it sees, whether the memory may be written and whether a conditional store has succeeded. Each hardware context has one slot holding a valid flag and a line address. A locked load fills or replaces the slot of the issuing context. Every write, whether an ordinary store or a conditional store, looks up all slots in the same cycle and drops every slot whose line matches the write's line, whichever context owns it.

An ordinary store is always allowed to write. A conditional store writes only if the slot of its own context is valid and holds the same line. The block then reports a one-bit result for that conditional store. The decision outputs are combinational from the request and the current table. The table itself changes on the next rising clock edge.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset no context holds a reservation, so a conditional store from any context fails.
- R2: Operation codes are 0 plain load, 1 locked load, 2 store, 3 conditional store. A locked load records its line for its own context, and a later conditional store from that context to that line succeeds with `mem_wr_en`=1 and `sc_resp_ok`=1.
- R3: A context keeps one reservation only. A second locked load replaces the line it holds, so a conditional store to the earlier line then fails.
- R4: The low `LINE_BITS` address bits are dropped both when a line is recorded and when lines are compared.
- R5: A valid ordinary store always drives `mem_wr_en`=1 and `sc_resp_vld`=0.
- R6: A store clears the matching reservation of every context, so later conditional stores to that line fail in all of them.
- R7: A conditional store without a valid slot of its own context on its line fails, with `mem_wr_en`=0 and `sc_resp_ok`=0.
- R8: Every conditional store, whether it passes or fails, clears all slots whose line matches it, including those of other contexts.
- R9: A write to one line leaves reservations on other lines untouched.
- R10: Plain loads and cycles with `req_vld`=0 never write and leave the table unchanged.
- R11: `sc_resp_vld` is 1 exactly for valid conditional stores, and `sc_resp_ok` is 1 only while `sc_resp_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical byte address |
| mem_wr_en | output | 1 | Memory may be written this cycle |
| sc_resp_vld | output | 1 | Result of a conditional store is present |
| sc_resp_ok | output | 1 | Conditional store succeeded (1) or failed (0) |

## Verification
The bench builds the tracker with ADDR_W=12, LINE_BITS=6 and the default eight contexts. With these values the address space is only 64 lines. A pseudo-random sweep confined to four lines, with random offsets inside each line, then makes shared reservations, cross-context clears, replacements and offset aliasing occur thousands of times. A reference table in the bench predicts every output. Directed sequences come first and cover each requirement on its own.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_LLOAD  = 2'd1,
      OP_STORE  = 2'd2,
      OP_SCOND  = 2'd3
   } llsc_op_e;
endpackage

// File: rtl/llsc_line_mask.sv
module llsc_line_mask #(
   parameter int ADDR_W    = 32,
   parameter int LINE_BITS = 6,
   localparam int LINE_W   = ADDR_W - LINE_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [LINE_W-1:0] line
);
   generate
      if (LINE_BITS == 0) begin : g_byte
         assign line = addr;
      end else begin : g_line
         assign line = addr[ADDR_W-1:LINE_BITS];
      end
   endgenerate
endmodule

// File: rtl/llsc_entry.sv
module llsc_entry #(
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              clr,
   input  logic [LINE_W-1:0] line_in,
   output logic              vld,
   output logic              match
);
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         line_q <= '0;
      end else if (set) begin
         vld    <= 1'b1;
         line_q <= line_in;
      end else if (clr) begin
         vld    <= 1'b0;
      end
   end

   assign match = vld && (line_q == line_in);
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
   import llsc_pkg::*;
(
   input  logic       req_vld,
   input  logic [1:0] req_op,
   input  logic       own_hit,
   output logic       is_write,
   output logic       do_set,
   output logic       mem_wr_en,
   output logic       sc_vld,
   output logic       sc_ok
);
   llsc_op_e op;

   always_comb begin
      op        = llsc_op_e'(req_op);
      is_write  = req_vld && (op == OP_STORE || op == OP_SCOND);
      do_set    = req_vld && (op == OP_LLOAD);
      sc_vld    = req_vld && (op == OP_SCOND);
      sc_ok     = sc_vld && own_hit;
      mem_wr_en = (req_vld && op == OP_STORE) || sc_ok;
   end
endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
   parameter int ADDR_W    = 32,
   parameter int CTX_W     = 3,
   parameter int LINE_BITS = 6,
   localparam int NUM_CTX  = 1 << CTX_W,
   localparam int LINE_W   = ADDR_W - LINE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [1:0]        req_op,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              mem_wr_en,
   output logic              sc_resp_vld,
   output logic              sc_resp_ok
);
   generate
      if (LINE_BITS < 0 || LINE_BITS >= ADDR_W) begin : g_bad_line
         $error("LINE_BITS must lie in [0, ADDR_W)");
      end
      if (CTX_W < 1 || CTX_W > 6) begin : g_bad_ctx
         $error("CTX_W must lie in [1, 6]");
      end
   endgenerate

   logic [LINE_W-1:0]  req_line;
   logic [NUM_CTX-1:0] ent_vld;
   logic [NUM_CTX-1:0] ent_match;
   logic               is_write;
   logic               do_set;
   logic               own_hit;

   llsc_line_mask #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_mask (
      .addr (req_addr),
      .line (req_line)
   );

   generate
      for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
         logic set_i;
         logic clr_i;
         assign set_i = do_set && (req_ctx == CTX_W'(i));
         assign clr_i = is_write && ent_match[i];
         llsc_entry #(.LINE_W(LINE_W)) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .set     (set_i),
            .clr     (clr_i),
            .line_in (req_line),
            .vld     (ent_vld[i]),
            .match   (ent_match[i])
         );
      end
   endgenerate

   assign own_hit = ent_match[req_ctx];

   llsc_decide u_decide (
      .req_vld   (req_vld),
      .req_op    (req_op),
      .own_hit   (own_hit),
      .is_write  (is_write),
      .do_set    (do_set),
      .mem_wr_en (mem_wr_en),
      .sc_vld    (sc_resp_vld),
      .sc_ok     (sc_resp_ok)
   );
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
   parameter int CTX_W    = 3,
   localparam int NUM_CTX = 1 << CTX_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_vld,
   input logic [1:0]         req_op,
   input logic [CTX_W-1:0]   req_ctx,
   input logic               mem_wr_en,
   input logic               sc_resp_vld,
   input logic               sc_resp_ok,
   input logic [NUM_CTX-1:0] ent_vld
);
   // R5
   a_r5_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_op == 2'd2) |-> (mem_wr_en && !sc_resp_vld));

   // R10
   a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld || req_op[1] == 1'b0) |-> !mem_wr_en);

   // R10
   a_r10_table_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld || req_op == 2'd0) |=> $stable(ent_vld));

   // R11
   a_r11_ok_inside_vld: assert property (@(posedge clk) disable iff (!rst_n)
      sc_resp_ok |-> (sc_resp_vld && mem_wr_en));

   // R2
   a_r2_ll_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_op == 2'd1) |=> ent_vld[$past(req_ctx)]);

   // R8
   a_r8_write_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_op[1]) |=> ((ent_vld & ~$past(ent_vld)) == '0));
endmodule

bind llsc_resv_tracker llsc_resv_chk #(.CTX_W(CTX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_vld     (req_vld),
   .req_op      (req_op),
   .req_ctx     (req_ctx),
   .mem_wr_en   (mem_wr_en),
   .sc_resp_vld (sc_resp_vld),
   .sc_resp_ok  (sc_resp_ok),
   .ent_vld     (ent_vld)
);

// File: tb/test_llsc_resv_tracker.sv
`timescale 1ns/1ps
module test_llsc_resv_tracker;
   localparam int AW = 12;
   localparam int CW = 3;
   localparam int LB = 6;
   localparam int NC = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_vld = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [CW-1:0] req_ctx = '0;
   logic [AW-1:0] req_addr = '0;
   logic          mem_wr_en, sc_resp_vld, sc_resp_ok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   bit        mv [NC];
   int        ml [NC];

   always #10 clk = ~clk;

   llsc_resv_tracker #(.ADDR_W(AW), .CTX_W(CW), .LINE_BITS(LB)) i_llsc_resv_tracker (
      .clk, .rst_n, .req_vld, .req_op, .req_ctx, .req_addr,
      .mem_wr_en, .sc_resp_vld, .sc_resp_ok
   );

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit v, input int op, input int ctx, input int addr, input string tag);
      int  line;
      bit  hit, ew, esv, eok;
      @(negedge clk);
      req_vld = v; req_op = 2'(op); req_ctx = CW'(ctx); req_addr = AW'(addr);
      #2;
      line = addr >> LB;
      hit  = mv[ctx] && (ml[ctx] == line);
      esv  = v && op == 3;
      eok  = esv && hit;
      ew   = (v && op == 2) || eok;
      check(tag, "mem_wr_en", mem_wr_en, ew);
      check(tag, "sc_resp_vld", sc_resp_vld, esv);
      check(tag, "sc_resp_ok", sc_resp_ok, eok);
      @(posedge clk);
      if (v && op == 1) begin
         mv[ctx] = 1'b1; ml[ctx] = line;
      end else if (v && op >= 2) begin
         for (int i = 0; i < NC; i++)
            if (mv[i] && ml[i] == line) mv[i] = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lf;
      for (int i = 0; i < NC; i++) begin mv[i] = 1'b0; ml[i] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset state at the ports, then no context can pass a conditional store
      step(0, 0, 0, 0, "R1");
      for (int c = 0; c < NC; c++) step(1, 3, c, 'h040, "R1");
      // R2
      step(1, 1, 2, 'h080, "R2");
      step(1, 3, 2, 'h080, "R2");
      // R3: replacement of a context's line
      step(1, 1, 3, 'h0C0, "R3");
      step(1, 1, 3, 'h100, "R3");
      step(1, 3, 3, 'h0C0, "R3");
      step(1, 3, 3, 'h100, "R3");
      // R4: offsets inside the line are ignored
      step(1, 1, 4, 'h145, "R4");
      step(1, 3, 4, 'h17F, "R4");
      // R5 / R6: plain store clears all contexts on the line
      step(1, 1, 0, 'h200, "R6");
      step(1, 1, 1, 'h210, "R6");
      step(1, 1, 5, 'h23F, "R6");
      step(1, 2, 7, 'h23A, "R5");
      step(1, 3, 0, 'h200, "R6");
      step(1, 3, 1, 'h200, "R6");
      step(1, 3, 5, 'h200, "R6");
      // R8: passing and failing conditional stores both clear others
      step(1, 1, 5, 'h300, "R8");
      step(1, 1, 6, 'h300, "R8");
      step(1, 3, 5, 'h300, "R8");
      step(1, 3, 6, 'h300, "R8");
      step(1, 1, 1, 'h340, "R8");
      step(1, 3, 2, 'h340, "R7");
      step(1, 3, 1, 'h340, "R8");
      // R9: other lines survive
      step(1, 1, 0, 'h380, "R9");
      step(1, 2, 3, 'h3C0, "R9");
      step(1, 3, 4, 'h3C4, "R9");
      step(1, 3, 0, 'h380, "R9");
      // R10: loads and idle cycles change nothing
      step(1, 1, 7, 'h400, "R10");
      step(1, 0, 7, 'h400, "R10");
      step(0, 3, 7, 'h400, "R10");
      step(0, 2, 2, 'h400, "R10");
      step(1, 3, 7, 'h400, "R10");
      // R11 plus mixed coverage: sweep on four lines with random offsets
      lf = 16'hACE1;
      for (int k = 0; k < 6000; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[13] | lf[14], int'(lf[1:0]), int'(lf[4:2]),
              int'({4'd0, lf[6:5], lf[12:7]}), "R11");
      end
      done = 1'b1;
      finish_run();
   end
endmodule